// File: doc/BRIEF.md
# Sparse Column Pivot Search Unit

This unit chooses the partial pivot for one elimination step of a sparse LU factorization. A column arrives as a stream of its stored nonzero entries only. Each entry carries a physical row index and an IEEE-754 single-precision value. The unit turns every physical index into a virtual index through an internal row-mapping table. It drops any entry whose virtual index lies below the current elimination step. Among the survivors it keeps the entry with the largest magnitude. When the column ends it reports that entry's virtual index and value, or a no-pivot flag when no entry survives.

The search accepts one entry per clock, so it can run alongside the row reads of the factorization. The mapping table is loaded through a separate write port. That port is locked while a column is being scanned, so a column never sees a mixture of old and new mappings. Results leave through a valid/ready output. While a result waits, new input is held off, unless the consumer takes the result in the same cycle.

Top module: `col_pivot_search`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1. Every map entry holds its own address (identity map), so row r maps to virtual index r.
- R2: A map write (map_we=1) in a cycle with no column in progress sets map[map_addr]=map_data. The new mapping applies to every later entry.
- R3: A map write is ignored in any cycle in which an entry is accepted, and in any cycle after the first accepted entry of a column up to and including the cycle its last entry is accepted.
- R4: An accepted entry whose virtual index map[in_row] is less than step_k is rejected and never becomes the pivot.
- R5: The pivot is the surviving entry with the largest magnitude. Magnitude is bits 30:0 of the value (sign bit 31 cleared), compared as an unsigned integer. out_value returns the entry's full 32-bit value, sign included, and out_vidx returns its virtual index.
- R6: When survivors tie on magnitude, the one accepted first is kept.
- R7: The column ends on the accepted entry with in_last=1. out_valid is 1 in the cycle after that entry is accepted, and is never 1 while a column is partly scanned.
- R8: If every entry of a column is rejected, the result has out_nopivot=1, out_vidx=0 and out_value=0.
- R9: An entry with in_empty=1 is never a candidate. A column made only of one in_empty=1, in_last=1 marker is an empty column and gives the R8 no-pivot result.
- R10: in_ready is 1 whenever no result is waiting, or the waiting result is taken in the same cycle. A column is therefore accepted at one entry per cycle with no stall while out_ready stays 1.
- R11: While out_valid=1 and out_ready=0, out_vidx, out_value and out_nopivot hold steady, out_valid stays 1 and in_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_k | input | 8 | Current elimination step; virtual indices below it are rejected |
| map_we | input | 1 | Map table write enable |
| map_addr | input | 8 | Physical row index to remap |
| map_data | input | 8 | Virtual index stored for map_addr |
| in_valid | input | 1 | Entry present |
| in_ready | output | 1 | Entry accepted when in_valid and in_ready are both 1 |
| in_row | input | 8 | Physical row index of the entry |
| in_val | input | 32 | Single-precision value of the entry |
| in_last | input | 1 | Entry is the final one of its column |
| in_empty | input | 1 | Entry is a placeholder, not a candidate |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_vidx | output | 8 | Virtual index of the pivot |
| out_value | output | 32 | Value of the pivot |
| out_nopivot | output | 1 | No eligible entry in the column |

## Verification
The hardest case to reach is a map write that lands on the exact cycle a column's first entry is accepted. In that cycle the column is not yet marked as in progress, so only the acceptance itself can block the write. The bench raises the write enable only in the cycle it sees in_ready high on an entry. It then proves the write had no effect by running a following column through that same row. A second hard case is a result stalled by the consumer while the next column waits. A pseudo-random out_ready pattern is run over many random columns, with near-equal magnitudes that force ties. During those stalls the held result and the blocked input are checked.

// File: rtl/pivot_pkg.sv
package pivot_pkg;
    localparam int FP_W  = 32;
    localparam int MAG_W = FP_W - 1;

    typedef logic [FP_W-1:0]  fp_word_t;
    typedef logic [MAG_W-1:0] fp_mag_t;

    function automatic fp_mag_t fp_magnitude(input fp_word_t w);
        return w[MAG_W-1:0];
    endfunction
endpackage

// File: rtl/pivot_rowmap.sv
module pivot_rowmap #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_block,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [IDX_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [IDX_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [IDX_W-1:0] map_d [DEPTH];
    logic [IDX_W-1:0] map_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            map_d[i] = map_q[i];
        end
        if (wr_en && !wr_block) begin
            map_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                map_q[i] <= IDX_W'(i);
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                map_q[i] <= map_d[i];
            end
        end
    end

    assign rd_data = map_q[rd_addr];

    AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_block) |=> (map_q[$past(wr_addr)] == $past(map_q[wr_addr]))); // R3
endmodule

// File: rtl/pivot_gate.sv
module pivot_gate
    import pivot_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             ent_fire,
    input  logic             ent_empty,
    input  logic [IDX_W-1:0] ent_vidx,
    input  logic [IDX_W-1:0] step_k,
    input  fp_word_t         ent_val,
    output logic             cand_ok,
    output fp_mag_t          cand_mag
);
    always_comb begin
        cand_ok  = ent_fire && !ent_empty && (ent_vidx >= step_k);
        cand_mag = fp_magnitude(ent_val);
    end
endmodule

// File: rtl/pivot_tracker.sv
module pivot_tracker
    import pivot_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ent_fire,
    input  logic             col_end,
    input  logic             cand_ok,
    input  logic [IDX_W-1:0] cand_idx,
    input  fp_word_t         cand_val,
    input  fp_mag_t          cand_mag,
    input  logic             out_ready,
    output logic             busy,
    output logic             res_valid,
    output logic [IDX_W-1:0] res_idx,
    output fp_word_t         res_val,
    output logic             res_nop
);
    typedef struct packed {
        logic             busy;
        logic             have;
        logic [IDX_W-1:0] bidx;
        fp_word_t         bval;
        fp_mag_t          bmag;
        logic             ov;
        logic             onop;
        logic [IDX_W-1:0] oidx;
        fp_word_t         oval;
    } trk_t;

    trk_t s_d, s_q;
    logic hit;
    logic             nh;
    logic [IDX_W-1:0] ni;
    fp_word_t         nv;
    fp_mag_t          nm;

    always_comb begin
        s_d = s_q;
        hit = cand_ok && (!s_q.have || (cand_mag > s_q.bmag));
        nh  = s_q.have || cand_ok;
        ni  = hit ? cand_idx : s_q.bidx;
        nv  = hit ? cand_val : s_q.bval;
        nm  = hit ? cand_mag : s_q.bmag;

        if (s_q.ov && out_ready) begin
            s_d.ov = 1'b0;
        end
        if (ent_fire) begin
            s_d.busy = !col_end;
        end
        if (col_end) begin
            s_d.ov   = 1'b1;
            s_d.onop = !nh;
            s_d.oidx = nh ? ni : '0;
            s_d.oval = nh ? nv : '0;
            s_d.have = 1'b0;
            s_d.bidx = '0;
            s_d.bval = '0;
            s_d.bmag = '0;
        end else if (hit) begin
            s_d.have = 1'b1;
            s_d.bidx = ni;
            s_d.bval = nv;
            s_d.bmag = nm;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = s_q.busy;
    assign res_valid = s_q.ov;
    assign res_idx   = s_q.oidx;
    assign res_val   = s_q.oval;
    assign res_nop   = s_q.onop;

    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ov && !out_ready) |=> (s_q.ov && $stable(s_q.oidx) && $stable(s_q.oval) && $stable(s_q.onop))); // R11
    AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        col_end |=> s_q.ov); // R7
    AST_NO_RESULT_MIDCOL: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> !s_q.ov); // R7
    AST_BEST_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.have && $past(s_q.have)) |-> (s_q.bmag >= $past(s_q.bmag))); // R5
    AST_NOPIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ov && s_q.onop) |-> (s_q.oidx == '0 && s_q.oval == '0)); // R8
endmodule

// File: rtl/col_pivot_search.sv
module col_pivot_search
    import pivot_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] step_k,
    input  logic             map_we,
    input  logic [IDX_W-1:0] map_addr,
    input  logic [IDX_W-1:0] map_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IDX_W-1:0] in_row,
    input  logic [FP_W-1:0]  in_val,
    input  logic             in_last,
    input  logic             in_empty,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [IDX_W-1:0] out_vidx,
    output logic [FP_W-1:0]  out_value,
    output logic             out_nopivot
);
    logic             fire;
    logic             col_end;
    logic             busy;
    logic [IDX_W-1:0] vidx;
    logic             cand_ok;
    fp_mag_t          cand_mag;

    assign in_ready = !out_valid || out_ready;
    assign fire     = in_valid && in_ready;
    assign col_end  = fire && in_last;

    pivot_rowmap #(.IDX_W(IDX_W)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (map_we),
        .wr_block (busy || fire),
        .wr_addr  (map_addr),
        .wr_data  (map_data),
        .rd_addr  (in_row),
        .rd_data  (vidx)
    );

    pivot_gate #(.IDX_W(IDX_W)) u_gate (
        .ent_fire  (fire),
        .ent_empty (in_empty),
        .ent_vidx  (vidx),
        .step_k    (step_k),
        .ent_val   (in_val),
        .cand_ok   (cand_ok),
        .cand_mag  (cand_mag)
    );

    pivot_tracker #(.IDX_W(IDX_W)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .ent_fire  (fire),
        .col_end   (col_end),
        .cand_ok   (cand_ok),
        .cand_idx  (vidx),
        .cand_val  (in_val),
        .cand_mag  (cand_mag),
        .out_ready (out_ready),
        .busy      (busy),
        .res_valid (out_valid),
        .res_idx   (out_vidx),
        .res_val   (out_value),
        .res_nop   (out_nopivot)
    );

    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R11
endmodule

// File: tb/col_pivot_search_tb.sv
module col_pivot_search_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  step_k = '0;
    logic        map_we = 1'b0;
    logic [7:0]  map_addr = '0, map_data = '0;
    logic        in_valid = 1'b0, in_last = 1'b0, in_empty = 1'b0;
    logic        in_ready;
    logic [7:0]  in_row = '0;
    logic [31:0] in_val = '0;
    logic        out_valid, out_ready = 1'b1, out_nopivot;
    logic [7:0]  out_vidx;
    logic [31:0] out_value;

    always #10 clk = ~clk;

    col_pivot_search u_dut (
        .clk(clk), .rst_n(rst_n), .step_k(step_k),
        .map_we(map_we), .map_addr(map_addr), .map_data(map_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row), .in_val(in_val),
        .in_last(in_last), .in_empty(in_empty),
        .out_valid(out_valid), .out_ready(out_ready), .out_vidx(out_vidx),
        .out_value(out_value), .out_nopivot(out_nopivot)
    );

    typedef struct packed { logic nop; logic [7:0] idx; logic [31:0] val; } res_t;
    res_t exp_q[$];
    logic [7:0] mdl_map [256];

    int errors = 0, checks = 0, cyc = 0, last_acc_cyc = -1, stalls = 0;
    int ready_mode = 0;
    bit done = 0;

    logic [7:0]  c_row [16];
    logic [31:0] c_val [16];
    bit          c_emp [16];
    int          c_n;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // monitor / scoreboard
    bit prev_ov = 0, hold_seen = 0;
    res_t held;
    logic [15:0] rlfsr = 16'hACE1;
    always @(negedge clk) begin
        rlfsr = {rlfsr[14:0], rlfsr[15] ^ rlfsr[13] ^ rlfsr[12] ^ rlfsr[10]};
        out_ready = (ready_mode == 0) ? 1'b1 : rlfsr[0];
        #1;
        if (rst_n) begin
            if (hold_seen) begin
                chk(out_valid && {out_nopivot, out_vidx, out_value} == held, "R11 held result",
                    64'({out_valid, out_nopivot, out_vidx, out_value}), 64'({1'b1, held}));
            end
            hold_seen = 0;
            if (out_valid && !prev_ov && last_acc_cyc >= 0) begin
                chk(cyc == last_acc_cyc, "R7 result latency", 64'(cyc), 64'(last_acc_cyc));
            end
            if (out_valid && !out_ready) begin
                chk(!in_ready, "R11 input blocked", 64'(in_ready), 64'(0));
                held = {out_nopivot, out_vidx, out_value};
                hold_seen = 1;
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R7 unexpected result", 64'(out_vidx), 64'(0));
                end else begin
                    res_t e;
                    e = exp_q.pop_front();
                    chk({out_nopivot, out_vidx, out_value} == e, "R4/R5/R6/R8 result",
                        64'({out_nopivot, out_vidx, out_value}), 64'(e));
                end
            end
            prev_ov = out_valid;
        end
    end

    task automatic put_entry(input logic [7:0] r, input logic [31:0] v, input bit lst, input bit emp,
                             input bit wr, input logic [7:0] wa, input logic [7:0] wd);
        @(negedge clk);
        in_valid = 1; in_row = r; in_val = v; in_last = lst; in_empty = emp;
        #2;
        while (!in_ready) begin stalls++; @(negedge clk); #2; end
        map_we = wr; map_addr = wa; map_data = wd;
        if (lst) last_acc_cyc = cyc + 1;
        @(posedge clk); #1;
        in_valid = 0; map_we = 0; in_last = 0; in_empty = 0;
    endtask

    task automatic map_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        map_we = 1; map_addr = a; map_data = d;
        @(negedge clk);
        map_we = 0;
        mdl_map[a] = d;
    endtask

    // run a column from c_row/c_val/c_emp; optional in-column writes (R3, ignored)
    task automatic run_col(input logic [7:0] k, input bit wr, input logic [7:0] wa, input logic [7:0] wd);
        res_t e;
        bit have = 0;
        logic [30:0] bm = '0;
        e = '0;
        for (int i = 0; i < c_n; i++) begin
            logic [7:0] vi;
            vi = mdl_map[c_row[i]];
            if (!c_emp[i] && vi >= k) begin
                if (!have || c_val[i][30:0] > bm) begin
                    have = 1; bm = c_val[i][30:0]; e.idx = vi; e.val = c_val[i];
                end
            end
        end
        e.nop = !have;
        exp_q.push_back(e);
        @(negedge clk);
        step_k = k;
        for (int i = 0; i < c_n; i++) begin
            put_entry(c_row[i], c_val[i], i == c_n - 1, c_emp[i], wr, wa, wd);
        end
    endtask

    task automatic set_e(input int i, input logic [7:0] r, input logic [31:0] v, input bit emp);
        c_row[i] = r; c_val[i] = v; c_emp[i] = emp;
    endtask

    task automatic drain();
        int guard = 0;
        while ((exp_q.size() != 0 || out_valid) && guard < 1000) begin
            @(negedge clk); guard++;
        end
        #3;
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] lf;
        for (int i = 0; i < 256; i++) mdl_map[i] = 8'(i);
        repeat (3) @(negedge clk);
        rst_n = 1;
        #2;
        // R1 reset state
        chk(!out_valid, "R1 out_valid after reset", 64'(out_valid), 64'(0));
        chk(in_ready, "R1 in_ready after reset", 64'(in_ready), 64'(1));
        // R1 identity map: row 77 -> 77
        c_n = 1; set_e(0, 8'd77, 32'h3F800000, 0);
        run_col(8'd0, 0, 0, 0); drain();
        // R5 largest magnitude, sign kept: -3.0 wins
        c_n = 3; set_e(0, 5, 32'h3F800000, 0); set_e(1, 9, 32'hC0400000, 0); set_e(2, 12, 32'h40000000, 0);
        run_col(8'd0, 0, 0, 0); drain();
        // R4 reject below step: row 3 (100.0) dropped, row 20 (-2.0) wins
        c_n = 3; set_e(0, 3, 32'h42C80000, 0); set_e(1, 11, 32'h3F800000, 0); set_e(2, 20, 32'hC0000000, 0);
        run_col(8'd10, 0, 0, 0); drain();
        // R6 tie keeps first
        c_n = 2; set_e(0, 30, 32'h40000000, 0); set_e(1, 31, 32'hC0000000, 0);
        run_col(8'd0, 0, 0, 0); drain();
        // R8 all rejected
        c_n = 2; set_e(0, 1, 32'h40000000, 0); set_e(1, 2, 32'h40400000, 0);
        run_col(8'd50, 0, 0, 0); drain();
        // R9 empty column, and placeholder not a candidate
        c_n = 1; set_e(0, 90, 32'h7F000000, 1);
        run_col(8'd0, 0, 0, 0); drain();
        c_n = 2; set_e(0, 91, 32'h7F000000, 1); set_e(1, 92, 32'h3F800000, 0);
        run_col(8'd0, 0, 0, 0); drain();
        // R2 idle writes swap rows 7 and 200
        map_write(8'd7, 8'd200); map_write(8'd200, 8'd7);
        c_n = 2; set_e(0, 7, 32'h3F800000, 0); set_e(1, 200, 32'h40A00000, 0);
        run_col(8'd100, 0, 0, 0); drain();
        // R3 writes during a column (incl. first-entry cycle) ignored
        c_n = 2; set_e(0, 40, 32'h3F800000, 0); set_e(1, 41, 32'h40000000, 0);
        run_col(8'd0, 1, 8'd41, 8'd0); drain();
        c_n = 1; set_e(0, 41, 32'h3F800000, 0);
        run_col(8'd30, 0, 0, 0); drain();
        chk(exp_q.size() == 0, "R3 column after ignored write consumed", 64'(exp_q.size()), 64'(0));
        // R10 eight entries, no stalls, back-to-back columns
        stalls = 0;
        c_n = 8;
        for (int i = 0; i < 8; i++) set_e(i, 8'(100 + i), {1'b0, 8'(120 + i), 23'h0}, 0);
        run_col(8'd0, 0, 0, 0);
        run_col(8'd0, 0, 0, 0);
        drain();
        chk(stalls == 0, "R10 stall-free stream", 64'(stalls), 64'(0));
        // random columns with stalling consumer (R5, R6, R11)
        ready_mode = 1;
        lf = 32'h1234_5679;
        for (int c = 0; c < 60; c++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            if (lf[3:0] == 0) begin
                drain();
                map_write(lf[15:8], lf[23:16]);
            end
            c_n = 1 + int'(lf[6:4]);
            for (int i = 0; i < c_n; i++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                set_e(i, lf[7:0], {lf[8], 8'(8'h7C + 8'(lf[11:9])), 23'h0}, lf[15:12] == 0);
            end
            run_col({2'b00, lf[21:16]}, lf[25:24] == 0, lf[7:0], lf[31:24]);
            if (c % 7 == 0) drain();
        end
        drain();
        ready_mode = 0;
        drain();
        chk(exp_q.size() == 0 && !out_valid, "R7 all results delivered", 64'(exp_q.size()), 64'(0));
        finish_run();
    end
endmodule